// File: doc/BRIEF.md
# Codec Power-Up Initialization Sequencer

This block is the host-side controller that takes an audio codec from power-on to normal operation. While the chip reset or a restart request is active, it holds the codec's active-low power-down line low. It then releases that line and waits for the codec's control logic to settle. The wait is longer when the codec's internal regulator is enabled.

After the settling wait, the sequencer steps through a short table of register writes. Each write goes out on a valid/ready request port that carries an 8-bit register address and an 8-bit data byte. A separate serial master turns each request into bus traffic. The last entry in the table rewrites the power-management register with its PLL-enable bit (bit 0) set. All configuration writes therefore land before the PLL starts.

The sequencer then waits out the worst-case PLL lock time and raises a level `init_done` flag. The lock time depends on whether the bit clock or the frame clock is the PLL reference. Every interval is a count of system clock cycles. Each count is derived from the `CLK_HZ` parameter and rounded up, so no minimum time is ever shortened.

Top module: `codec_init_seq`

## Requirements
- R1: While `rst_n` is low, and in the cycle after `restart` is sampled high, `codec_pd_n`, `wr_valid` and `init_done` are all low.
- R2: After reset release or a restart, `codec_pd_n` stays low for ceil(150 ns × CLK_HZ) cycles, and never fewer than one.
- R3: With `ldo_en` high, `codec_pd_n` is high for ceil(10 ms × CLK_HZ) cycles before the first write request appears.
- R4: With `ldo_en` low, that settling interval is ceil(1 ms × CLK_HZ) cycles.
- R5: The default write table is issued in this exact order, as (address, data) pairs: (0x01, 0x04), (0x03, 0x38), (0x05, 0x22), (0x01, 0x05). The last pair is the PLL enable.
- R6: `wr_valid` stays high with `wr_addr` and `wr_data` unchanged until a cycle where `wr_ready` is high. The next entry is offered in the very next cycle.
- R7: With `ref_frame` low (bit clock is the reference), `init_done` rises ceil(2 ms × CLK_HZ) cycles after the PLL-enable handshake.
- R8: With `ref_frame` high (frame clock is the reference), that lock interval is ceil(40 ms × CLK_HZ) cycles.
- R9: Once `init_done` is high, it stays high and no write is requested until reset or restart. Holding `wr_ready` high in that state has no effect.
- R10: `ldo_en` is sampled only when the power-down line is released. `ref_frame` is sampled only at the PLL-enable handshake. Changing either one during the wait that follows does not alter that wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously upstream |
| restart | input | 1 | Synchronous request to rerun the whole sequence from power-down |
| ldo_en | input | 1 | High when the codec's internal regulator is enabled (longer settling wait) |
| ref_frame | input | 1 | High when the frame clock is the PLL reference, low for the bit clock |
| codec_pd_n | output | 1 | Active-low power-down line to the codec |
| wr_valid | output | 1 | Register write request valid |
| wr_ready | input | 1 | Serial master accepts the current write request |
| wr_addr | output | 8 | Register address of the current request |
| wr_data | output | 8 | Data byte of the current request |
| init_done | output | 1 | Codec initialized, PLL lock interval elapsed |

## Verification
Every output is decoded from registered state, so each result appears one clock edge after the cycle that causes it. Examples: power-down drops one edge after `restart`, the next table entry shows one edge after a handshake, and `init_done` rises one edge after the lock counter expires. The bench drives inputs and samples outputs on the falling edge. It counts falling-edge samples in each phase (power-down low, settling, lock wait), so each measured count equals the interval length in cycles exactly. An odd `CLK_HZ` makes every rounded-up interval one cycle longer than the truncated value, which exposes any rounding error.

// File: rtl/codec_init_pkg.sv
package codec_init_pkg;

  typedef enum logic [2:0] {
    ST_HOLD   = 3'd0,
    ST_SETTLE = 3'd1,
    ST_WRITE  = 3'd2,
    ST_LOCK   = 3'd3,
    ST_READY  = 3'd4
  } seq_state_e;

  typedef struct packed {
    logic [7:0] addr;
    logic [7:0] data;
  } reg_write_t;

  // Round a duration in nanoseconds up to whole clock cycles, minimum one.
  function automatic longint unsigned ns_to_cycles(input longint unsigned ns,
                                                   input longint unsigned hz);
    longint unsigned c;
    c = (ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
    if (c == 64'd0) c = 64'd1;
    return c;
  endfunction

  function automatic longint unsigned max2(input longint unsigned a,
                                           input longint unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/cis_delay_timer.sv
module cis_delay_timer #(
  parameter int          W       = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= RST_VAL;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == '0);

  // R2 R3 R7: a running wait drops by exactly one per cycle, no skips
  a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - W'(1)));

  // R9: an expired counter stays expired until reloaded
  a_r9_count_rest: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q == '0) |=> (cnt_q == '0));

endmodule

// File: rtl/cis_reg_rom.sv
module cis_reg_rom
  import codec_init_pkg::*;
#(
  parameter int               NUM_WR    = 4,
  parameter int               IDX_W     = 2,
  parameter logic [NUM_WR*8-1:0] ADDR_PACK = '0,
  parameter logic [NUM_WR*8-1:0] DATA_PACK = '0
) (
  input  logic [IDX_W-1:0] idx,
  output reg_write_t       entry
);

  reg_write_t tbl [NUM_WR];

  for (genvar g = 0; g < NUM_WR; g++) begin : g_entry
    assign tbl[g].addr = ADDR_PACK[g*8 +: 8];
    assign tbl[g].data = DATA_PACK[g*8 +: 8];
  end

  always_comb begin
    entry = '0;
    for (int i = 0; i < NUM_WR; i++) begin
      if (idx == IDX_W'(i)) entry = tbl[i];
    end
  end

endmodule

// File: rtl/codec_init_seq.sv
module codec_init_seq
  import codec_init_pkg::*;
#(
  parameter longint unsigned CLK_HZ          = 64'd50_000_000,
  parameter longint unsigned HOLD_NS         = 64'd150,
  parameter longint unsigned SETTLE_REG_NS   = 64'd10_000_000,
  parameter longint unsigned SETTLE_NOREG_NS = 64'd1_000_000,
  parameter longint unsigned LOCK_BCLK_NS    = 64'd2_000_000,
  parameter longint unsigned LOCK_FCLK_NS    = 64'd40_000_000,
  parameter int              NUM_WR          = 4,
  // entry 0 in the low byte; the last entry must be the PLL enable
  parameter logic [NUM_WR*8-1:0] ROM_ADDR = {8'h01, 8'h05, 8'h03, 8'h01},
  parameter logic [NUM_WR*8-1:0] ROM_DATA = {8'h05, 8'h22, 8'h38, 8'h04}
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic       ldo_en,
  input  logic       ref_frame,
  output logic       codec_pd_n,
  output logic       wr_valid,
  input  logic       wr_ready,
  output logic [7:0] wr_addr,
  output logic [7:0] wr_data,
  output logic       init_done
);

  localparam longint unsigned C_HOLD   = ns_to_cycles(HOLD_NS, CLK_HZ);
  localparam longint unsigned C_SET_R  = ns_to_cycles(SETTLE_REG_NS, CLK_HZ);
  localparam longint unsigned C_SET_N  = ns_to_cycles(SETTLE_NOREG_NS, CLK_HZ);
  localparam longint unsigned C_LOCK_B = ns_to_cycles(LOCK_BCLK_NS, CLK_HZ);
  localparam longint unsigned C_LOCK_F = ns_to_cycles(LOCK_FCLK_NS, CLK_HZ);
  localparam longint unsigned C_MAX    =
    max2(max2(C_HOLD, C_SET_R), max2(max2(C_SET_N, C_LOCK_B), C_LOCK_F));
  localparam int CNT_W = $clog2(C_MAX + 64'd1);
  localparam int IDX_W = (NUM_WR > 1) ? $clog2(NUM_WR) : 1;

  localparam logic [CNT_W-1:0] HOLD_M1   = CNT_W'(C_HOLD - 64'd1);
  localparam logic [CNT_W-1:0] SET_R_M1  = CNT_W'(C_SET_R - 64'd1);
  localparam logic [CNT_W-1:0] SET_N_M1  = CNT_W'(C_SET_N - 64'd1);
  localparam logic [CNT_W-1:0] LOCK_B_M1 = CNT_W'(C_LOCK_B - 64'd1);
  localparam logic [CNT_W-1:0] LOCK_F_M1 = CNT_W'(C_LOCK_F - 64'd1);
  localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(NUM_WR - 1);

  seq_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             idx_en;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_expired;
  reg_write_t       cur_entry;

  // next-state logic
  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    tmr_load = 1'b0;
    tmr_val  = HOLD_M1;
    if (restart) begin
      state_d  = ST_HOLD;
      idx_d    = '0;
      tmr_load = 1'b1;
      tmr_val  = HOLD_M1;
    end else begin
      unique case (state_q)
        ST_HOLD: begin
          if (tmr_expired) begin
            state_d  = ST_SETTLE;
            tmr_load = 1'b1;
            tmr_val  = ldo_en ? SET_R_M1 : SET_N_M1;
          end
        end
        ST_SETTLE: begin
          if (tmr_expired) begin
            state_d = ST_WRITE;
            idx_d   = '0;
          end
        end
        ST_WRITE: begin
          if (wr_ready) begin
            if (idx_q == LAST_IDX) begin
              state_d  = ST_LOCK;
              tmr_load = 1'b1;
              tmr_val  = ref_frame ? LOCK_F_M1 : LOCK_B_M1;
            end else begin
              idx_d = idx_q + IDX_W'(1);
            end
          end
        end
        ST_LOCK: begin
          if (tmr_expired) state_d = ST_READY;
        end
        ST_READY: state_d = ST_READY;
        default:  state_d = ST_HOLD;
      endcase
    end
  end

  assign idx_en = (idx_d != idx_q);

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HOLD;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (idx_en) begin
      idx_q <= idx_d;
    end
  end

  cis_delay_timer #(
    .W       (CNT_W),
    .RST_VAL (HOLD_M1)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  cis_reg_rom #(
    .NUM_WR    (NUM_WR),
    .IDX_W     (IDX_W),
    .ADDR_PACK (ROM_ADDR),
    .DATA_PACK (ROM_DATA)
  ) u_rom (
    .idx   (idx_q),
    .entry (cur_entry)
  );

  // outputs decoded from registered state
  assign codec_pd_n = (state_q != ST_HOLD);
  assign wr_valid   = (state_q == ST_WRITE);
  assign init_done  = (state_q == ST_READY);
  assign wr_addr    = cur_entry.addr;
  assign wr_data    = cur_entry.data;

  // R1: restart forces power-down and silences the request port next cycle
  a_r1_restart_pd: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!codec_pd_n && !wr_valid && !init_done));

  // R1 R2: no request or ready flag while the codec is powered down
  a_r2_quiet_in_pd: assert property (@(posedge clk) disable iff (!rst_n)
    !codec_pd_n |-> (!wr_valid && !init_done));

  // R6: a pending request holds its address and data
  a_r6_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready && !restart) |=>
      (wr_valid && $stable(wr_addr) && $stable(wr_data)));

  // R9: ready flag is sticky until restart
  a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done && !restart) |=> init_done);

  // R9: no write request once initialized
  a_r9_no_req_done: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> !wr_valid);

  // R5 R7: the lock wait is entered only from the last write handshake
  a_r5_lock_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WRITE && wr_ready && idx_q == LAST_IDX && !restart)
      |=> (state_q == ST_LOCK));

endmodule

// File: tb/tb_codec_init_seq.sv
module tb_codec_init_seq;

  localparam longint unsigned TB_HZ = 64'd100_003;

  logic       clk;
  logic       rst_n;
  logic       restart;
  logic       ldo_en;
  logic       ref_frame;
  logic       codec_pd_n;
  logic       wr_valid;
  logic       wr_ready;
  logic [7:0] wr_addr;
  logic [7:0] wr_data;
  logic       init_done;

  int tests;
  int fails;
  int cyc;

  codec_init_seq #(.CLK_HZ(TB_HZ)) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (restart),
    .ldo_en     (ldo_en),
    .ref_frame  (ref_frame),
    .codec_pd_n (codec_pd_n),
    .wr_valid   (wr_valid),
    .wr_ready   (wr_ready),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .init_done  (init_done)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // expected write order from R5
  localparam logic [7:0] EXP_ADDR [4] = '{8'h01, 8'h03, 8'h05, 8'h01};
  localparam logic [7:0] EXP_DATA [4] = '{8'h04, 8'h38, 8'h22, 8'h05};

  // interval lengths at 100003 Hz, rounded up:
  // 150 ns -> 1, 1 ms -> 101, 10 ms -> 1001, 2 ms -> 201, 40 ms -> 4001
  localparam int EXP_HOLD = 1;

  // vector: {ldo, ref, stall[3:0], exp_settle[15:0], exp_lock[15:0]}
  localparam int NV = 4;
  localparam logic [37:0] VEC [NV] = '{
    {1'b1, 1'b0, 4'd0, 16'd1001, 16'd201},
    {1'b0, 1'b0, 4'd2, 16'd101,  16'd201},
    {1'b0, 1'b1, 4'd5, 16'd101,  16'd4001},
    {1'b1, 1'b1, 4'd1, 16'd1001, 16'd4001}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_restart();
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
    chk(!codec_pd_n && !wr_valid && !init_done, "R1 restart", codec_pd_n, 0);
  endtask

  // Walk one complete sequence starting at a negedge with power-down low.
  task automatic run_seq(input bit ldo, input bit rf, input int stall,
                         input int exp_set, input int exp_lock, input bit flip);
    int c;
    logic [7:0] a;
    logic [7:0] d;
    bit stable_ok;
    bit quiet_ok;
    c = 0;
    while (!codec_pd_n && c < 100) begin
      c++;
      @(negedge clk);
    end
    chk(c == EXP_HOLD, "R2 hold cycles", c, EXP_HOLD);
    c = 0;
    while (codec_pd_n && !wr_valid && c < 5000) begin
      c++;
      if (flip && c == 10) ldo_en = ~ldo_en;
      @(negedge clk);
    end
    chk(c == exp_set, ldo ? "R3 settle regulator on" : "R4 settle regulator off",
        c, exp_set);
    if (flip) chk(c == exp_set, "R10 ldo_en change ignored", c, exp_set);
    for (int k = 0; k < 4; k++) begin
      chk(wr_valid, "R6 request present", wr_valid, 1);
      a = wr_addr;
      d = wr_data;
      stable_ok = 1'b1;
      for (int s = 0; s < stall; s++) begin
        @(negedge clk);
        if (!wr_valid || wr_addr != a || wr_data != d) stable_ok = 1'b0;
      end
      if (stall > 0) chk(stable_ok, "R6 request held while stalled", wr_addr, a);
      chk(a == EXP_ADDR[k], "R5 address order", a, EXP_ADDR[k]);
      chk(d == EXP_DATA[k], "R5 data order", d, EXP_DATA[k]);
      wr_ready = 1'b1;
      @(negedge clk);
      wr_ready = 1'b0;
    end
    c = 0;
    quiet_ok = 1'b1;
    while (!init_done && c < 10000) begin
      c++;
      if (wr_valid) quiet_ok = 1'b0;
      if (flip && c == 10) ref_frame = ~ref_frame;
      @(negedge clk);
    end
    chk(quiet_ok, "R9 no request during lock", 0, 0);
    chk(c == exp_lock, rf ? "R8 lock frame ref" : "R7 lock bit ref", c, exp_lock);
    if (flip) chk(c == exp_lock, "R10 ref_frame change ignored", c, exp_lock);
  endtask

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    tests = 0;
    fails = 0;
    cyc = 0;
    rst_n = 1'b0;
    restart = 1'b0;
    ldo_en = 1'b1;
    ref_frame = 1'b0;
    wr_ready = 1'b0;
    repeat (3) @(negedge clk);
    chk(!codec_pd_n && !wr_valid && !init_done, "R1 reset state", codec_pd_n, 0);
    rst_n = 1'b1;

    // first pass straight out of reset, then the vector table
    run_seq(1'b1, 1'b0, 0, 1001, 201, 1'b0);
    for (int v = 0; v < NV; v++) begin
      ldo_en = VEC[v][37];
      ref_frame = VEC[v][36];
      pulse_restart();
      run_seq(VEC[v][37], VEC[v][36], int'(VEC[v][35:32]),
              int'(VEC[v][31:16]), int'(VEC[v][15:0]), 1'b0);
    end

    // R9: ready flag sticky, wr_ready ignored
    wr_ready = 1'b1;
    repeat (20) @(negedge clk);
    chk(init_done && !wr_valid && codec_pd_n, "R9 done holds with ready high",
        init_done, 1);
    wr_ready = 1'b0;

    // R1 R2: restart in the middle of settling reruns the full sequence
    ldo_en = 1'b0;
    ref_frame = 1'b0;
    pulse_restart();
    repeat (50) @(negedge clk);
    chk(codec_pd_n && !wr_valid, "R4 still settling", codec_pd_n, 1);
    pulse_restart();
    run_seq(1'b0, 1'b0, 0, 101, 201, 1'b0);

    // R10: select inputs change during their waits
    ldo_en = 1'b1;
    ref_frame = 1'b1;
    pulse_restart();
    run_seq(1'b1, 1'b1, 0, 1001, 4001, 1'b1);

    // R1: asynchronous reset during the lock wait
    ldo_en = 1'b0;
    ref_frame = 1'b1;
    pulse_restart();
    repeat (120) @(negedge clk);
    wr_ready = 1'b1;
    repeat (6) @(negedge clk);
    wr_ready = 1'b0;
    repeat (30) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(!codec_pd_n && !wr_valid && !init_done, "R1 async reset", codec_pd_n, 0);
    @(negedge clk);
    rst_n = 1'b1;
    run_seq(1'b0, 1'b1, 0, 101, 4001, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule